// File: doc/BRIEF.md
# Bicubic Subpixel Interpolation Filter

This block builds one square block of motion-compensated luma samples from a reference window. The window is streamed into it one row per cycle. A horizontal and a vertical subpixel code (0 to 3 each) select a fixed four-tap kernel per direction: code 2 is the half-sample position, and codes 1 and 3 are the two quarter positions, which are mirror images of each other.

- **One direction fractional.** The block runs a single 8-bit pass.
- **Both directions fractional.** It first filters vertically into signed 16-bit intermediates, with a shift that depends on the code pair. It then filters those intermediates horizontally.

The rounding for each pass is derived from a rounding-control bit. Every result is clamped to 0..255. In average mode, each clamped result is averaged with the matching existing destination pixel.

A controller pulses `start` with the codes while `ready` is high. It then supplies BLK+3 window rows. Window row i holds reference row i-1 and window column c holds reference column c-1. Pixel c of a row sits at bits [8c+7:8c]. Once the first four window rows are in, every accepted row yields one output row on the following cycle. The destination pixels to be averaged travel with the row that completes each output row. The integer-position case (both codes zero) and fetching the window are handled elsewhere.

Top module: `bicubic_mc`

## Requirements
- R1: After reset `ready` is 1, and `out_valid` and `done` are 0.
- R2: A `start` is taken only while `ready` is 1 and at least one of `hmode`/`vmode` is nonzero; `ready` is then 0 on the next cycle. A `start` with both codes zero, or any `start` while busy, has no effect, and codes, `rnd` and `avg_en` are latched only when a start is taken.
- R3: A block consumes exactly BLK+3 rows. The row accepted as window row k (k >= 3) yields output row k-3, with `out_valid` high in the cycle after acceptance, so a block gives exactly BLK output strobes. No strobe appears for the first three rows.
- R4: Code 2 uses taps (-1, 9, 9, -1), code 1 uses (-4, 53, 18, -3) and code 3 uses (-3, 18, 53, -4), applied to the neighbours at offsets -1, 0, +1, +2 in that order.
- R5: With `hmode`=0, output (x,y) filters reference column x over rows y-1..y+2. With r = 1-rnd, a code-2 sum becomes (s+8-r)>>4 and a code-1/3 sum becomes (s+32-r)>>6, both arithmetic shifts.
- R6: With `vmode`=0, output (x,y) filters reference row y over columns x-1..x+2, using the same rounding as R5 with r = rnd.
- R7: With both codes nonzero, let w(0..3) = {0,5,1,5} and sh = (w(hmode)+w(vmode))>>1. Vertical intermediates for reference columns -1..BLK+1 are (s + 2^(sh-1) + rnd - 1)>>sh. The horizontal pass over them gives (s + 64 - rnd)>>7.
- R8: Every filtered result is clamped to 0..255 before output or averaging.
- R9: With `avg_en` latched at 1, each output pixel is (f + d + 1)>>1, where f is the clamped filter result and d the matching `dst_pix` byte.
- R10: `done` is high for one cycle, together with the last `out_valid` of the block, and `ready` is 1 in that same cycle.
- R11: Cycles with `row_valid` low are not consumed and give no output strobe, so rows may arrive with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block with the codes present |
| hmode | input | 2 | Horizontal subpixel code |
| vmode | input | 2 | Vertical subpixel code |
| rnd | input | 1 | Rounding-control bit |
| avg_en | input | 1 | 1 = average with destination, 0 = overwrite |
| row_valid | input | 1 | A window row is present on `row_pix` |
| row_pix | input | 8*(BLK+3) | One window row, column c at bits [8c+7:8c] |
| dst_pix | input | 8*BLK | Destination row for averaging, sampled with rows k >= 3 |
| ready | output | 1 | Idle, a start may be taken |
| out_valid | output | 1 | `out_pix` holds an output row |
| out_pix | output | 8*BLK | Output row, pixel x at bits [8x+7:8x] |
| done | output | 1 | Last output row of the block |

## Verification
The bench builds the block with BLK=4, which gives a 7x7 window and 4x4 output. At that size every one of the fifteen nonzero code pairs can be crossed with both rounding values, both write modes and four data patterns: random, alternating extremes that drive the sums past both clamp limits, all-white and all-black. The sweep stays within a few thousand cycles. The smaller size also lets row gaps and a start issued mid-block be exercised on each code pair.

// File: rtl/bicubic_mc.sv
module bicubic_mc #(
  parameter int BLK = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           hmode,
  input  logic [1:0]           vmode,
  input  logic                 rnd,
  input  logic                 avg_en,
  input  logic                 row_valid,
  input  logic [8*(BLK+3)-1:0] row_pix,
  input  logic [8*BLK-1:0]     dst_pix,
  output logic                 ready,
  output logic                 out_valid,
  output logic [8*BLK-1:0]     out_pix,
  output logic                 done
);
  localparam int WIN = BLK + 3;
  localparam int RW  = 8 * WIN;
  localparam int CW  = $clog2(WIN + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [1:0]    hm_q, vm_q;
  logic          rnd_q, avg_q;
  logic [RW-1:0] r0, r1, r2;

  wire take = start && !busy && (hmode != 2'd0 || vmode != 2'd0);
  wire acc  = busy && row_valid;
  assign ready = !busy;

  function automatic logic signed [23:0] px(input logic [RW-1:0] row, input int c);
    return $signed({16'd0, row[c*8 +: 8]});
  endfunction

  function automatic logic signed [23:0] tap4(input logic [1:0] m,
      input logic signed [23:0] a, input logic signed [23:0] b,
      input logic signed [23:0] c, input logic signed [23:0] d);
    case (m)
      2'd1:    return 24'sd53 * b + 24'sd18 * c - 24'sd4 * a - 24'sd3 * d;
      2'd2:    return 24'sd9 * (b + c) - a - d;
      default: return 24'sd18 * b + 24'sd53 * c - 24'sd3 * a - 24'sd4 * d;
    endcase
  endfunction

  function automatic logic signed [23:0] one_pass(input logic [1:0] m,
      input logic signed [23:0] s, input logic r);
    logic signed [23:0] rr;
    rr = $signed({23'd0, r});
    if (m == 2'd2) return (s + 24'sd8 - rr) >>> 4;
    return (s + 24'sd32 - rr) >>> 6;
  endfunction

  function automatic logic [7:0] clip8(input logic signed [23:0] v);
    if (v < 0) return 8'd0;
    if (v > 24'sd255) return 8'd255;
    return v[7:0];
  endfunction

  function automatic logic [3:0] wt(input logic [1:0] m);
    case (m)
      2'd1, 2'd3: return 4'd5;
      2'd2:       return 4'd1;
      default:    return 4'd0;
    endcase
  endfunction

  logic [3:0]         vsh;
  logic signed [23:0] vrnd;
  logic signed [15:0] mid [WIN];
  logic signed [23:0] fres [BLK];
  logic [8*BLK-1:0]   nxt;

  assign vsh  = (wt(hm_q) + wt(vm_q)) >> 1;
  assign vrnd = (vsh == 4'd0) ? 24'sd0 :
                $signed(24'd1 << (vsh - 4'd1)) + $signed({23'd0, rnd_q}) - 24'sd1;

  always_comb begin
    for (int c = 0; c < WIN; c++)
      mid[c] = 16'((tap4(vm_q, px(r0, c), px(r1, c), px(r2, c), px(row_pix, c)) + vrnd) >>> vsh);
    for (int x = 0; x < BLK; x++) begin
      if (hm_q == 2'd0)
        fres[x] = one_pass(vm_q, tap4(vm_q, px(r0, x+1), px(r1, x+1), px(r2, x+1),
                                      px(row_pix, x+1)), !rnd_q);
      else if (vm_q == 2'd0)
        fres[x] = one_pass(hm_q, tap4(hm_q, px(r1, x), px(r1, x+1), px(r1, x+2),
                                      px(r1, x+3)), rnd_q);
      else
        fres[x] = (tap4(hm_q, 24'(mid[x]), 24'(mid[x+1]), 24'(mid[x+2]), 24'(mid[x+3]))
                   + 24'sd64 - $signed({23'd0, rnd_q})) >>> 7;
    end
    for (int x = 0; x < BLK; x++) begin
      logic [8:0] sum;
      sum = {1'b0, clip8(fres[x])} + {1'b0, dst_pix[x*8 +: 8]} + 9'd1;
      nxt[x*8 +: 8] = avg_q ? sum[8:1] : clip8(fres[x]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; hm_q <= '0; vm_q <= '0; rnd_q <= 1'b0; avg_q <= 1'b0;
      r0 <= '0; r1 <= '0; r2 <= '0;
      out_valid <= 1'b0; out_pix <= '0; done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (take) begin
        busy <= 1'b1; cnt <= '0;
        hm_q <= hmode; vm_q <= vmode; rnd_q <= rnd; avg_q <= avg_en;
      end
      if (acc) begin
        r0 <= r1; r1 <= r2; r2 <= row_pix;
        cnt <= cnt + 1'b1;
        if (cnt >= CW'(3)) begin
          out_valid <= 1'b1;
          out_pix   <= nxt;
        end
        if (cnt == CW'(WIN - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module bicubic_mc_chk #(
  parameter int BLK = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] hmode,
  input logic [1:0] vmode,
  input logic       row_valid,
  input logic       ready,
  input logic       out_valid,
  input logic       done
);
  logic [15:0] nval;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nval <= '0;
    else if (done) nval <= '0;
    else if (out_valid) nval <= nval + 16'd1;

  AST_TAKE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start && (hmode != 2'd0 || vmode != 2'd0) |=> !ready); // R2
  AST_ZERO_CODES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start && hmode == 2'd0 && vmode == 2'd0 |=> ready); // R2
  AST_STROBE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(row_valid) && !$past(ready)); // R3
  AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> nval == 16'(BLK - 1)); // R3
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && ready); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind bicubic_mc bicubic_mc_chk #(.BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
  .row_valid(row_valid), .ready(ready), .out_valid(out_valid), .done(done)
);

// File: tb/sim_bicubic_mc.sv
`timescale 1ns/1ps
module sim_bicubic_mc;
  localparam int BLK = 4;
  localparam int WIN = BLK + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rnd_i = 1'b0, avg_i = 1'b0, row_valid = 1'b0;
  logic [1:0] hmode = 2'd0, vmode = 2'd0;
  logic [8*WIN-1:0] row_pix = '0;
  logic [8*BLK-1:0] dst_pix = '0;
  logic ready, out_valid, done;
  logic [8*BLK-1:0] out_pix;

  int checks = 0, errors = 0;
  int win [WIN][WIN];
  int dstv [BLK][BLK];
  int expv [BLK][BLK];
  int tmp [BLK][WIN];

  always #2.5 clk = ~clk;

  bicubic_mc #(.BLK(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
    .rnd(rnd_i), .avg_en(avg_i), .row_valid(row_valid), .row_pix(row_pix),
    .dst_pix(dst_pix), .ready(ready), .out_valid(out_valid), .out_pix(out_pix),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tapm(int m, int a, int b, int c, int d);
    if (m == 1) return -4*a + 53*b + 18*c - 3*d;
    if (m == 2) return -a + 9*b + 9*c - d;
    return -3*a + 18*b + 53*c - 4*d;
  endfunction

  function automatic int clipv(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  function automatic int single(int m, int s, int r);
    return (m == 2) ? ((s + 8 - r) >>> 4) : ((s + 32 - r) >>> 6);
  endfunction

  function automatic int wv(int m);
    return (m == 0) ? 0 : ((m == 2) ? 1 : 5);
  endfunction

  task automatic model(input int hm, input int vm, input int r, input int av);
    int sh, f;
    sh = (wv(hm) + wv(vm)) >>> 1;
    for (int y = 0; y < BLK; y++)
      for (int c = 0; c < WIN; c++)
        tmp[y][c] = (tapm(vm, win[y][c], win[y+1][c], win[y+2][c], win[y+3][c])
                     + (1 << (sh > 0 ? sh - 1 : 0)) + r - 1) >>> sh;
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) begin
        if (hm == 0)
          f = single(vm, tapm(vm, win[y][x+1], win[y+1][x+1], win[y+2][x+1], win[y+3][x+1]), 1 - r);
        else if (vm == 0)
          f = single(hm, tapm(hm, win[y+1][x], win[y+1][x+1], win[y+1][x+2], win[y+1][x+3]), r);
        else
          f = (tapm(hm, tmp[y][x], tmp[y][x+1], tmp[y][x+2], tmp[y][x+3]) + 64 - r) >>> 7;
        f = clipv(f);
        expv[y][x] = av ? ((f + dstv[y][x] + 1) >>> 1) : f;
      end
  endtask

  task automatic run_block(input int hm, input int vm, input int r, input int av,
                           input int pat, input bit gaps, input bit midstart);
    logic [8*BLK-1:0] er;
    string tag;
    for (int i = 0; i < WIN; i++)
      for (int j = 0; j < WIN; j++)
        case (pat)
          0: win[i][j] = int'($urandom_range(0, 255));
          1: win[i][j] = ((i + j) % 2 == 1) ? 255 : 0;
          2: win[i][j] = 255;
          default: win[i][j] = 0;
        endcase
    for (int i = 0; i < BLK; i++)
      for (int j = 0; j < BLK; j++) dstv[i][j] = int'($urandom_range(0, 255));
    model(hm, vm, r, av);
    tag = (hm == 0) ? "R4 R5" : ((vm == 0) ? "R4 R6" : "R4 R7");
    if (pat == 1) tag = {tag, " R8"};
    if (av != 0) tag = {tag, " R9"};

    @(negedge clk);
    start = 1'b1; hmode = 2'(hm); vmode = 2'(vm); rnd_i = 1'(r); avg_i = 1'(av);
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R2 ready after take", 64'(ready), 64'd0);
    for (int k = 0; k < WIN; k++) begin
      if (gaps && (k % 2 == 1)) begin
        row_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 gap strobe", 64'(out_valid), 64'd0);
      end
      row_valid = 1'b1;
      for (int c = 0; c < WIN; c++) row_pix[c*8 +: 8] = 8'(win[k][c]);
      for (int x = 0; x < BLK; x++) dst_pix[x*8 +: 8] = (k >= 3) ? 8'(dstv[k-3][x]) : 8'd0;
      if (midstart && k == 4) begin
        start = 1'b1; hmode = 2'(3 - hm); vmode = 2'd2; rnd_i = ~rnd_i; avg_i = ~avg_i;
      end
      @(negedge clk);
      row_valid = 1'b0; start = 1'b0;
      if (k >= 3) begin
        for (int x = 0; x < BLK; x++) er[x*8 +: 8] = 8'(expv[k-3][x]);
        chk(out_valid == 1'b1 && out_pix == er, tag, 64'(out_pix), 64'(er));
        chk(done == (k == WIN - 1), "R10 done timing", 64'(done), 64'(k == WIN - 1));
        if (k == WIN - 1) chk(ready == 1'b1, "R10 ready with done", 64'(ready), 64'd1);
      end else begin
        chk(out_valid == 1'b0, "R3 no early strobe", 64'(out_valid), 64'd0);
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R3 quiet after block", 64'({out_valid, done}), 64'd0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 reset state",
        64'({ready, out_valid, done}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 idle after reset",
        64'({ready, out_valid, done}), 64'b100);
    start = 1'b1; hmode = 2'd0; vmode = 2'd0;
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b1, "R2 zero codes ignored", 64'(ready), 64'd1);
    for (int i = 0; i < WIN; i++) begin
      row_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 rows while idle", 64'(out_valid), 64'd0);
    end
    row_valid = 1'b0;
    for (int hm = 0; hm < 4; hm++)
      for (int vm = 0; vm < 4; vm++) begin
        if (hm == 0 && vm == 0) continue;
        for (int r = 0; r < 2; r++)
          for (int av = 0; av < 2; av++)
            for (int pat = 0; pat < 4; pat++)
              run_block(hm, vm, r, av, pat, pat == 0 && r == 1, pat == 1 && av == 0);
      end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule